// File: doc/BRIEF.md
# Relative Branch Target Calculator

This block turns the offset fields of a PC-relative instruction into a destination address for a 16-bit microcontroller core. For each request it receives the address of the byte that follows the whole branch instruction, a format code, the raw offset bytes, the sign bit taken from a loop-primitive postbyte, and a taken flag that is decided elsewhere. It returns the offset widened to 16 bits, the branch destination, and the next program counter.

Four offset formats share one adder:
- a one-byte signed offset for short branches;
- a one-byte signed offset for bit-test branches;
- a two-byte signed offset for long branches that follow a prebyte;
- a 9-bit signed offset for loop primitives. Its sign bit is carried in the register-select postbyte, not in the offset byte.

Requests enter through a valid/ready port, and results leave through a valid/ready port held in one register stage. The input side is ready whenever the stage is empty or its contents are being taken in the same cycle. A result that is offered but not taken stays unchanged until the consumer accepts it. No new request is accepted while a result is held back.

Top module: `branch_target_calc`

## Requirements
- R1: Format code 0 (short) uses `in_off_lo` as a signed 8-bit offset (-128..+127). The destination is `in_next_addr` plus that offset.
- R2: Format code 1 (long) uses `{in_off_hi, in_off_lo}` as a signed 16-bit offset (-32768..+32767), with the high byte first.
- R3: Format code 2 (loop) forms a signed 9-bit offset (-256..+255) from `{in_loop_sign, in_off_lo}`. `in_loop_sign` carries bit 4 of the loop postbyte, so postbyte 8'h01 with byte 8'h25 gives +37 and postbyte 8'h11 with byte 8'h05 gives -251.
- R4: Format code 3 (bit-test) uses `in_off_lo` as a signed 8-bit offset.
- R5: When taken, the next PC equals the destination. When not taken, the next PC equals `in_next_addr`, for every format.
- R6: A zero offset gives a next PC equal to `in_next_addr`, whether taken or not.
- R7: Format codes 4..7 raise `out_error`, force the offset to 0, and make both the destination and the next PC equal `in_next_addr` regardless of `in_taken`. Codes 0..3 give `out_error` = 0.
- R8: All address sums wrap modulo 2^16.
- R9: `in_ready` = !`out_valid` || `out_ready`. A request accepted at one clock edge appears with `out_valid` after that edge. While `out_valid` && !`out_ready`, every output holds and no request is accepted.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_format | input | 3 | Offset format code |
| in_next_addr | input | 16 | Address after the full branch instruction |
| in_off_hi | input | 8 | High offset byte (long format) |
| in_off_lo | input | 8 | Low or only offset byte |
| in_loop_sign | input | 1 | Sign bit from loop postbyte (bit 4) |
| in_taken | input | 1 | Branch decision |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_offset | output | 16 | Sign-extended offset |
| out_target | output | 16 | Branch destination |
| out_next_pc | output | 16 | Selected next PC |
| out_error | output | 1 | Unused format code seen |

## Verification
Every one of the eight format codes is swept over all 256 low offset bytes, both loop-sign values and both taken values. Base addresses are chosen near 16'h0000, 16'h8000 and 16'hFFFF, so that both wrap directions are hit.

This sweep separates the formats from one another:
- The long-format case changes the high byte while the others must ignore it.
- The loop format flips the sign bit while the 8-bit formats must ignore it.
- The error codes must produce the same result for either sign.

A separate sweep over the high byte with boundary low bytes covers the full 16-bit range. A stall sequence holds the output while a second request is offered, which shows that the hold is kept and the refusal is correct.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ADDR_W        = 16;
  localparam int BYTE_W        = 8;
  localparam int FMT_W         = 3;
  localparam int LOOP_OFF_W    = BYTE_W + 1;

  localparam logic [FMT_W-1:0] FMT_SHORT   = 3'd0;
  localparam logic [FMT_W-1:0] FMT_LONG    = 3'd1;
  localparam logic [FMT_W-1:0] FMT_LOOP    = 3'd2;
  localparam logic [FMT_W-1:0] FMT_BITTEST = 3'd3;

  typedef struct packed {
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] next_pc;
    logic              error;
  } brt_result_t;
endpackage

// File: rtl/brt_offset_sel.sv
module brt_offset_sel
  import brt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [FMT_W-1:0]  fmt,
  input  logic [BYTE_W-1:0] off_hi,
  input  logic [BYTE_W-1:0] off_lo,
  input  logic              loop_sign,
  output logic [AW-1:0]     offset,
  output logic              bad_fmt
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic signed [BYTE_W-1:0]     s_byte;
  logic signed [WIDE_W-1:0]     s_wide;
  logic signed [LOOP_OFF_W-1:0] s_loop;

  assign s_byte = $signed(off_lo);
  assign s_wide = $signed({off_hi, off_lo});
  assign s_loop = $signed({loop_sign, off_lo});

  always_comb begin
    bad_fmt = 1'b0;
    unique case (fmt)
      FMT_SHORT,
      FMT_BITTEST: offset = AW'(s_byte);
      FMT_LONG:    offset = AW'(s_wide);
      FMT_LOOP:    offset = AW'(s_loop);
      default: begin
        offset  = '0;
        bad_fmt = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/brt_target_add.sv
module brt_target_add
  import brt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          taken,
  input  logic          bad_fmt,
  output logic [AW-1:0] target,
  output logic [AW-1:0] next_pc
);
  // Sum is truncated to AW bits: modulo 2^AW wrap.
  assign target  = base + offset;
  assign next_pc = (taken && !bad_fmt) ? target : base;
endmodule

// File: rtl/brt_out_stage.sv
module brt_out_stage
  import brt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_valid,
  output logic        up_ready,
  input  brt_result_t up_data,
  output logic        dn_valid,
  input  logic        dn_ready,
  output brt_result_t dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  // R9: a stalled result must not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  // R9: an accepted request is presented on the next cycle
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid && dn_data == $past(up_data));
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc
  import brt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FMT_W-1:0]  in_format,
  input  logic [ADDR_W-1:0] in_next_addr,
  input  logic [BYTE_W-1:0] in_off_hi,
  input  logic [BYTE_W-1:0] in_off_lo,
  input  logic              in_loop_sign,
  input  logic              in_taken,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_offset,
  output logic [ADDR_W-1:0] out_target,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic              out_error
);
  logic [ADDR_W-1:0] c_offset, c_target, c_next_pc;
  logic              c_bad;
  brt_result_t       c_res, r_res;

  brt_offset_sel #(.AW(ADDR_W)) u_sel (
    .fmt(in_format), .off_hi(in_off_hi), .off_lo(in_off_lo),
    .loop_sign(in_loop_sign), .offset(c_offset), .bad_fmt(c_bad)
  );

  brt_target_add #(.AW(ADDR_W)) u_add (
    .base(in_next_addr), .offset(c_offset), .taken(in_taken),
    .bad_fmt(c_bad), .target(c_target), .next_pc(c_next_pc)
  );

  always_comb begin
    c_res.offset  = c_offset;
    c_res.target  = c_target;
    c_res.next_pc = c_next_pc;
    c_res.error   = c_bad;
  end

  brt_out_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(c_res),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(r_res)
  );

  assign out_offset  = r_res.offset;
  assign out_target  = r_res.target;
  assign out_next_pc = r_res.next_pc;
  assign out_error   = r_res.error;

  // R10: an empty stage always accepts
  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3: loop sign bit fills the upper offset bits
  p_loop_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_format == FMT_LOOP |=>
      out_offset[ADDR_W-1:BYTE_W] == {(ADDR_W-BYTE_W){$past(in_loop_sign)}});

  // R2: long offset bytes pass through high byte first
  p_long_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_format == FMT_LONG |=>
      out_offset[2*BYTE_W-1:0] == {$past(in_off_hi), $past(in_off_lo)});

  // R7: an unused code never branches
  p_err_nobranch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_error |-> out_offset == '0 && out_next_pc == out_target);

  // R6: zero offset lands on the following instruction
  p_zero_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_offset == '0 |-> out_next_pc == out_target);
endmodule

// File: tb/sim_branch_target_calc.sv
module sim_branch_target_calc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_format = '0;
  logic [15:0] in_next_addr = '0;
  logic [7:0]  in_off_hi = '0;
  logic [7:0]  in_off_lo = '0;
  logic        in_loop_sign = 1'b0;
  logic        in_taken = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_offset, out_target, out_next_pc;
  logic        out_error;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_format(in_format), .in_next_addr(in_next_addr), .in_off_hi(in_off_hi),
    .in_off_lo(in_off_lo), .in_loop_sign(in_loop_sign), .in_taken(in_taken),
    .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
    .out_target(out_target), .out_next_pc(out_next_pc), .out_error(out_error)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_offset(int fmt, int hi, int lo, int sgn);
    int v;
    case (fmt)
      0, 3: v = (lo >= 128) ? lo - 256 : lo;
      1: begin v = hi * 256 + lo; if (v >= 32768) v = v - 65536; end
      2: v = sgn ? lo - 256 : lo;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic apply(int fmt, int base, int hi, int lo, int sgn, int tk);
    int off, tgt, npc, raw;
    string req;
    @(negedge clk);
    in_format = 3'(fmt); in_next_addr = 16'(base); in_off_hi = 8'(hi);
    in_off_lo = 8'(lo); in_loop_sign = sgn[0]; in_taken = tk[0];
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    off = exp_offset(fmt, hi, lo, sgn);
    raw = base + off;
    tgt = raw & 16'hFFFF;
    npc = (tk != 0 && fmt < 4) ? tgt : base;
    if (fmt >= 4)                   req = "R7";
    else if (off == 0)              req = "R6";
    else if (raw < 0 || raw > 65535) req = "R8";
    else if (fmt == 0)              req = "R1";
    else if (fmt == 1)              req = "R2";
    else if (fmt == 2)              req = "R3";
    else                            req = "R4";
    check("R9", "out_valid", int'(out_valid), 1);
    check(req, "offset", int'(out_offset), off & 16'hFFFF);
    check(req, "target", int'(out_target), tgt);
    check((fmt >= 4) ? "R7" : "R5", "next_pc", int'(out_next_pc), npc);
    check("R7", "error", int'(out_error), (fmt >= 4) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "out_valid", int'(out_valid), 0);
    check("R10", "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "out_valid after release", int'(out_valid), 0);

    // Main sweep: all formats, all low bytes, both signs, both decisions
    for (int f = 0; f < 8; f++)
      for (int lo = 0; lo < 256; lo++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++) begin
            int base;
            case (lo % 4)
              0: base = 16'h0000;
              1: base = 16'hFFF0;
              2: base = 16'h8000;
              default: base = 16'h1234;
            endcase
            apply(f, base, lo ^ 8'hA5, lo, s, t);
          end

    // Long format: full high-byte sweep with boundary low bytes
    for (int hi = 0; hi < 256; hi++)
      for (int k = 0; k < 4; k++) begin
        int lo;
        case (k)
          0: lo = 8'h00;
          1: lo = 8'h7F;
          2: lo = 8'h80;
          default: lo = 8'hFF;
        endcase
        apply(1, (hi * 97 + k * 16381) & 16'hFFFF, hi, lo, k & 1, (hi >> 1) & 1);
      end

    // Loop examples: postbyte 8'h01/8'h25 forward, 8'h11/8'h05 backward
    apply(2, 16'h2000, 0, 8'h25, 0, 1);
    check("R3", "forward target", int'(out_target), 16'h2025);
    apply(2, 16'h2000, 0, 8'h05, 1, 1);
    check("R3", "backward target", int'(out_target), 16'h2000 - 251);

    // Back-pressure: R9
    @(negedge clk);
    out_ready = 1'b0;
    apply(1, 16'h4000, 8'h01, 8'h02, 0, 1);
    in_format = 3'd0; in_next_addr = 16'h0010; in_off_lo = 8'hF0;
    in_valid = 1'b1;
    check("R9", "in_ready while stalled", int'(in_ready), 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R9", "held valid", int'(out_valid), 1);
    check("R9", "held target", int'(out_target), 16'h4102);
    check("R9", "held next_pc", int'(out_next_pc), 16'h4102);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9", "drained", int'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule